// File: doc/BRIEF.md
# Destination Address Hash Filter

This block decides, for each received frame, whether the frame is accepted, judging only by its destination address. The six address bytes come in one at a time on a byte stream, the first of them marked by a start flag. While the bytes arrive, the block updates a reflected CRC-32 over them and keeps the whole 48-bit address. One cycle after the sixth byte it presents a decision, which stays valid until the next frame starts.

A unicast address is accepted if it equals the programmed station address. If it does not, it is looked up in an individual hash table. A group address is looked up in a group hash table. Each table has 64 bits, and six bits of the CRC pick one of them. The broadcast address is always accepted. A promiscuous control bit accepts every frame. Software programs the station address, both tables and the control word through a simple register write port.

Top module: `mcast_hash_filter`

## Requirements
- R1: After reset, `dec_valid` and `dec_accept` are 0, and every register (station address, both tables, control) holds zero.
- R2: A write with `cfg_we` high stores `cfg_wdata` into the register chosen by `cfg_sel`: 0 = station low word, 1 = station high word, 2 = group table upper half (indices 63:32), 3 = group table lower half (indices 31:0), 4 = individual table upper half, 5 = individual table lower half, 6 = control. Other codes are ignored.
- R3: A byte with `byte_vld` and `sof` both high is taken as address byte 0 of a new frame. `dec_valid` is 0 in the cycle after it.
- R4: `dec_valid` rises in the cycle after the sixth address byte. It then holds, together with `dec_accept`, until the next start byte, and further bytes do not change it. `dec_accept` is 0 whenever `dec_valid` is 0.
- R5: The address FF:FF:FF:FF:FF:FF is accepted, whatever the tables hold.
- R6: A unicast address (bit 0 of byte 0 clear) is accepted when byte 0..3 equal station low word bits 31:24, 23:16, 15:8, 7:0 and byte 4..5 equal station high word bits 31:24, 23:16.
- R7: A group address (bit 0 of byte 0 set) is accepted exactly when bit `idx` of the group table is set. `idx` is bits 31:26 of the CRC-32 over bytes 0..5 in arrival order, computed LSB first with reflected polynomial 0xEDB88320, initial value 0xFFFFFFFF and no final inversion.
- R8: A unicast address that does not match the station address is accepted exactly when bit `idx` (as in R7) of the individual table is set.
- R9: With control bit 3 set, every frame is accepted.
- R10: With both halves of the group table all ones, every group address is accepted.
- R11: Cycles with `byte_vld` low between address bytes do not advance the frame, and bytes that arrive before any start byte are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select |
| cfg_wdata | input | 32 | Register write data |
| byte_vld | input | 1 | Address byte valid |
| sof | input | 1 | Marks the byte as byte 0 of a frame |
| byte_data | input | 8 | Destination address byte |
| dec_valid | output | 1 | Decision valid |
| dec_accept | output | 1 | Frame accepted (meaningful while `dec_valid` is high) |

## Verification
Directed frames cover the separate paths one at a time:
- broadcast with empty tables, which separates the broadcast rule from any table lookup;
- an exact station match next to a one-byte mismatch, which catches byte-order and field-position mistakes;
- group and unicast-miss addresses checked first against an empty table and then with only the computed bit set, which shows that the CRC index and the choice of table are both right.

Random addresses, tables, station values and promiscuous settings, with random gaps between bytes, are checked against a bench model of the CRC and of the decision. Extra bytes after the sixth one and back-to-back starts test hold and restart.

// File: rtl/mcast_hash_filter.sv
module mcast_hash_filter #(
  parameter logic [31:0] CRC_POLY    = 32'hEDB88320,
  parameter int          PROMISC_BIT = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [2:0]  cfg_sel,
  input  logic [31:0] cfg_wdata,
  input  logic        byte_vld,
  input  logic        sof,
  input  logic [7:0]  byte_data,
  output logic        dec_valid,
  output logic        dec_accept
);
  localparam int NBYTES = 6;
  localparam int IDX_W  = 6;
  localparam int CNT_W  = $clog2(NBYTES + 1);

  logic [31:0] stn_lo, stn_hi, grp_hi, grp_lo, ind_hi, ind_lo, ctrl_q;
  logic [CNT_W-1:0] cnt;
  logic [31:0] crc_q, crc_nx;
  logic [47:0] addr_q, addr_nx;
  logic        first, take, last, accept_nx, stn_hit;
  logic [IDX_W-1:0] idx;

  function automatic logic [31:0] crc_byte(input logic [31:0] c, input logic [7:0] b);
    logic [31:0] r;
    r = c ^ {24'd0, b};
    for (int i = 0; i < 8; i++)
      r = r[0] ? ((r >> 1) ^ CRC_POLY) : (r >> 1);
    return r;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stn_lo <= '0; stn_hi <= '0; grp_hi <= '0; grp_lo <= '0;
      ind_hi <= '0; ind_lo <= '0; ctrl_q <= '0;
    end else if (cfg_we) begin
      case (cfg_sel)
        3'd0: stn_lo <= cfg_wdata;
        3'd1: stn_hi <= cfg_wdata;
        3'd2: grp_hi <= cfg_wdata;
        3'd3: grp_lo <= cfg_wdata;
        3'd4: ind_hi <= cfg_wdata;
        3'd5: ind_lo <= cfg_wdata;
        3'd6: ctrl_q <= cfg_wdata;
        default: ;
      endcase
    end
  end

  assign first   = byte_vld & sof;
  assign take    = first | (byte_vld && cnt != '0 && cnt < CNT_W'(NBYTES));
  assign crc_nx  = crc_byte(first ? 32'hFFFF_FFFF : crc_q, byte_data);
  assign addr_nx = {addr_q[39:0], byte_data};
  assign last    = take && !first && cnt == CNT_W'(NBYTES - 1);
  assign idx     = crc_nx[31:32-IDX_W];
  assign stn_hit = addr_nx == {stn_lo, stn_hi[31:16]};

  assign accept_nx = ctrl_q[PROMISC_BIT] | (&addr_nx) |
                     (addr_nx[40] ? {grp_hi, grp_lo}[idx]
                                  : (stn_hit | {ind_hi, ind_lo}[idx]));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt        <= '0;
      crc_q      <= '0;
      addr_q     <= '0;
      dec_valid  <= 1'b0;
      dec_accept <= 1'b0;
    end else if (take) begin
      cnt    <= first ? CNT_W'(1) : cnt + CNT_W'(1);
      crc_q  <= crc_nx;
      addr_q <= addr_nx;
      if (first) begin
        dec_valid  <= 1'b0;
        dec_accept <= 1'b0;
      end else if (last) begin
        dec_valid  <= 1'b1;
        dec_accept <= accept_nx;
      end
    end
  end
endmodule

// File: rtl/mcast_hash_filter_chk.sv
module mcast_hash_filter_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       byte_vld,
  input logic       sof,
  input logic       dec_valid,
  input logic       dec_accept,
  input logic       promisc,
  input logic [2:0] cnt
);
  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    byte_vld && sof |=> !dec_valid); // R3
  AST_DECISION_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid && !(byte_vld && sof) |=> dec_valid && $stable(dec_accept)); // R4
  AST_ACCEPT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_valid |-> !dec_accept); // R4
  AST_VALID_AFTER_SIXTH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dec_valid) |-> $past(cnt) == 3'd5 && $past(byte_vld)); // R4
  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= 3'd6); // R11
  AST_PROMISC_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dec_valid) && $past(promisc) |-> dec_accept); // R9
endmodule

bind mcast_hash_filter mcast_hash_filter_chk u_chk (
  .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .sof(sof),
  .dec_valid(dec_valid), .dec_accept(dec_accept),
  .promisc(ctrl_q[PROMISC_BIT]), .cnt(cnt)
);

// File: tb/sim_mcast_hash_filter.sv
module sim_mcast_hash_filter;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic cfg_we = 0, byte_vld = 0, sof = 0;
  logic [2:0] cfg_sel = 0;
  logic [31:0] cfg_wdata = 0;
  logic [7:0] byte_data = 0;
  logic dec_valid, dec_accept;

  int checks = 0, errors = 0;
  logic [31:0] m_stn_lo = 0, m_stn_hi = 0, m_grp_hi = 0, m_grp_lo = 0;
  logic [31:0] m_ind_hi = 0, m_ind_lo = 0, m_ctrl = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mcast_hash_filter u0 (.*);

  function automatic logic [31:0] ref_crc(input logic [47:0] a);
    logic [31:0] c = 32'hFFFF_FFFF;
    for (int k = 0; k < 6; k++) begin
      c ^= {24'd0, a[47-8*k -: 8]};
      for (int j = 0; j < 8; j++) c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
    end
    return c;
  endfunction

  function automatic logic [5:0] ref_idx(input logic [47:0] a);
    logic [31:0] c = ref_crc(a);
    return c[31:26];
  endfunction

  function automatic logic ref_accept(input logic [47:0] a);
    logic [63:0] g = {m_grp_hi, m_grp_lo};
    logic [63:0] n = {m_ind_hi, m_ind_lo};
    logic [5:0] ix = ref_idx(a);
    if (m_ctrl[3]) return 1'b1;
    if (a == 48'hFFFF_FFFF_FFFF) return 1'b1;
    if (a[40]) return g[ix];
    if (a == {m_stn_lo, m_stn_hi[31:16]}) return 1'b1;
    return n[ix];
  endfunction

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] s, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_sel = s; cfg_wdata = d;
    case (s)
      3'd0: m_stn_lo = d; 3'd1: m_stn_hi = d; 3'd2: m_grp_hi = d;
      3'd3: m_grp_lo = d; 3'd4: m_ind_hi = d; 3'd5: m_ind_lo = d;
      3'd6: m_ctrl = d; default: ;
    endcase
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic send(input logic [47:0] a, input int maxgap, input string req);
    @(negedge clk);
    byte_vld = 1; sof = 1; byte_data = a[47:40];
    @(negedge clk);
    sof = 0; byte_vld = 0;
    chk(dec_valid == 0, "R3", 32'(dec_valid), 0);
    for (int i = 1; i < 6; i++) begin
      byte_vld = 0;
      repeat ($urandom_range(maxgap, 0)) @(negedge clk);
      byte_vld = 1; byte_data = a[47-8*i -: 8];
      @(negedge clk);
      byte_vld = 0;
      if (i < 5) chk(dec_valid == 0, "R11", 32'(dec_valid), 0);
    end
    chk(dec_valid == 1, "R4", 32'(dec_valid), 1);
    chk(dec_accept == ref_accept(a), req, 32'(dec_accept), 32'(ref_accept(a)));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [47:0] a;
    logic [5:0] ix;
    logic keep;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(dec_valid == 0 && dec_accept == 0, "R1", {dec_valid, dec_accept}, 0);
    rst_n = 1;

    // R11: bytes before any start are ignored
    @(negedge clk);
    byte_vld = 1; byte_data = 8'hAA;
    repeat (8) @(negedge clk);
    byte_vld = 0;
    chk(dec_valid == 0, "R11", 32'(dec_valid), 0);

    // R1: empty tables reject a group address
    send(48'h0100_5E00_0001, 0, "R1");
    // R5
    send(48'hFFFF_FFFF_FFFF, 2, "R5");

    // R6, R2
    wr(3'd0, 32'h0012_3456); wr(3'd1, 32'h789A_0000);
    send(48'h0012_3456_789A, 1, "R6");
    chk(dec_accept == 1, "R6", 32'(dec_accept), 1);
    send(48'h0012_3456_789B, 1, "R8");
    chk(dec_accept == 0, "R8", 32'(dec_accept), 0);

    // R8: individual table bit
    a = 48'h0012_3456_789B; ix = ref_idx(a);
    if (ix >= 32) wr(3'd4, 32'd1 << (ix - 32)); else wr(3'd5, 32'd1 << ix);
    send(a, 0, "R8");
    chk(dec_accept == 1, "R8", 32'(dec_accept), 1);

    // R7: group table bit, with R2 halves
    a = 48'h0300_0000_0042; ix = ref_idx(a);
    send(a, 0, "R7");
    chk(dec_accept == 0, "R7", 32'(dec_accept), 0);
    if (ix >= 32) wr(3'd2, 32'd1 << (ix - 32)); else wr(3'd3, 32'd1 << ix);
    send(a, 0, "R7");
    chk(dec_accept == 1, "R7", 32'(dec_accept), 1);

    // R4: extra bytes ignored, decision held
    keep = dec_accept;
    byte_vld = 1; byte_data = 8'h55;
    repeat (5) @(negedge clk);
    byte_vld = 0;
    @(negedge clk);
    chk(dec_valid == 1 && dec_accept == keep, "R4", {dec_valid, dec_accept}, {1'b1, keep});

    // R2: unused select code ignored
    wr(3'd7, 32'hFFFF_FFFF);
    send(48'h0300_0000_0043, 0, "R2");

    // R10
    wr(3'd2, 32'hFFFF_FFFF); wr(3'd3, 32'hFFFF_FFFF);
    for (int n = 0; n < 20; n++) begin
      a = {$urandom, $urandom} | 48'h0100_0000_0000;
      send(a, 1, "R10");
      chk(dec_accept == 1, "R10", 32'(dec_accept), 1);
    end

    // R9
    wr(3'd2, 0); wr(3'd3, 0); wr(3'd4, 0); wr(3'd5, 0); wr(3'd6, 32'h8);
    send(48'h0200_0000_0001, 0, "R9");
    chk(dec_accept == 1, "R9", 32'(dec_accept), 1);
    send(48'h0100_0000_0001, 0, "R9");
    chk(dec_accept == 1, "R9", 32'(dec_accept), 1);

    // random mix
    for (int n = 0; n < 300; n++) begin
      if (n % 25 == 0) begin
        wr(3'd2, $urandom); wr(3'd3, $urandom);
        wr(3'd4, $urandom); wr(3'd5, $urandom);
        wr(3'd0, $urandom); wr(3'd1, $urandom);
        wr(3'd6, ($urandom_range(7, 0) == 0) ? 32'h8 : 32'h0);
      end
      case ($urandom_range(3, 0))
        0: a = {m_stn_lo, m_stn_hi[31:16]};
        1: a = 48'hFFFF_FFFF_FFFF;
        default: a = {$urandom, $urandom};
      endcase
      send(a, 3, a[40] ? "R7" : "R8");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule